// File: doc/BRIEF.md
# Byte-Register SPI Command Engine

This block is a small SPI master that a host drives through eight byte-wide registers. The host stores an opcode, up to three address bytes and one trailing data byte. It then writes a control byte. The control byte picks how many bytes go out, picks how many response bytes come back, and starts the transfer. The engine holds chip-select low for the whole command. It shifts each byte out in the order the wire expects, clocks in up to three response bytes, and reports busy until chip-select is high again. The host then reads the response bytes from three fixed offsets.

The block also has a page-program pass-through mode. In that mode the opcode goes out and chip-select stays low. Each later host write to the data offset is then sent straight to the flash, until the host writes zero to the control register. The serial clock comes from a fixed divider of the system clock.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip-select is high, the serial clock is low, the busy flag is 0, and offsets 1 to 4 read back 0x00.
- R2: Offsets 1 (opcode), 2, 3, 4 (address bytes) and 7 (data) are writable. Reads of offsets 1 to 4 return the stored value. A read of offset 0 returns the busy flag in bit 7 and zero in bits 6:0.
- R3: A write to offset 0 whose bits [7:4] are 0x5, made while the engine is idle, starts a command. Busy reads 1 from the cycle after that write.
- R4: Control bits [1:0] select the bytes sent. Code 0 sends the opcode only. Code 1 sends the opcode and then the offset-7 byte. Code 2 sends the opcode, then offset 4, offset 3 and offset 2. Code 3 sends the same four bytes followed by the offset-7 byte.
- R5: Control bits [3:2] give a read count N from 0 to 3. After the write bytes, the engine sends N bytes of 0x00. The bytes received during them are stored at offsets 5, 6 and 7 in the order they arrived. Response offsets not reached by N keep their previous value.
- R6: The serial interface runs in SPI mode 0. The clock idles low. Data goes out MSB first and is sampled on the rising clock edge. MOSI does not change while the clock is high. The clock is low whenever chip-select is high.
- R7: Chip-select stays low from the first bit to the last bit of a command. Busy falls only after chip-select has returned high.
- R8: While busy is 1, further start writes and writes to offsets 1 to 4 and 7 are ignored.
- R9: A control write whose bits [7:4] are neither 0x5 nor 0x3 starts nothing while the engine is idle.
- R10: A control write with bits [7:4] equal to 0x3 sends the opcode and leaves chip-select low. Busy is set while the opcode shifts and clears afterwards. Each later write to offset 7 sends that byte, with busy set while it shifts.
- R11: In page-program mode, writing 0x00 to offset 0 while busy is 0 raises chip-select and returns the engine to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register offset for reads and writes |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip-select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions assume the host issues at most one write per cycle. They also assume the host does not expect writes made during busy to take effect, and that page-program mode is entered only through a control write. The bench keeps to these assumptions. Each task polls the busy bit at offset 0 before it continues. The only writes it makes during busy are the deliberate ones that test R8. A behavioural flash model in the bench records every byte on MOSI. It answers with bytes equal to 0xA0 plus the byte's position in the transfer, so the expected response values follow from the write length alone.

// File: rtl/spi_cmd_pkg.sv
// Shared constants and types for the SPI command engine.
// Assumes an 8-bit register bus with eight offsets.
package spi_cmd_pkg;
    localparam int BYTE_W   = 8;
    localparam int OFS_W    = 3;
    localparam int RESP_CNT = 3;

    localparam logic [OFS_W-1:0] OFS_CTRL  = 3'd0;
    localparam logic [OFS_W-1:0] OFS_OPC   = 3'd1;
    localparam logic [OFS_W-1:0] OFS_A_LO  = 3'd2;
    localparam logic [OFS_W-1:0] OFS_A_MID = 3'd3;
    localparam logic [OFS_W-1:0] OFS_A_HI  = 3'd4;
    localparam logic [OFS_W-1:0] OFS_RSP0  = 3'd5;
    localparam logic [OFS_W-1:0] OFS_RSP1  = 3'd6;
    localparam logic [OFS_W-1:0] OFS_DATA  = 3'd7;

    localparam logic [3:0] NIB_RUN  = 4'h5;
    localparam logic [3:0] NIB_PAGE = 4'h3;

    localparam logic [1:0] WC_OPC     = 2'd0;
    localparam logic [1:0] WC_OPC_DAT = 2'd1;
    localparam logic [1:0] WC_OPC_ADR = 2'd2;
    localparam logic [1:0] WC_FULL    = 2'd3;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SHIFT,
        SQ_CLOSE,
        SQ_PAGE
    } seq_state_t;

    // Number of bytes sent for a write-length code.
    function automatic logic [3:0] wr_bytes(input logic [1:0] code);
        case (code)
            WC_OPC:     wr_bytes = 4'd1;
            WC_OPC_DAT: wr_bytes = 4'd2;
            WC_OPC_ADR: wr_bytes = 4'd4;
            default:    wr_bytes = 4'd5;
        endcase
    endfunction
endpackage

// File: rtl/spi_cmd_regs.sv
// Host register file: command bytes, response bytes and the read mux.
// Assumes one bus access per cycle. Writes are dropped while busy.
module spi_cmd_regs
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [OFS_W-1:0]  bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              busy,
    input  logic              rsp_we,
    input  logic [1:0]        rsp_idx,
    input  logic [BYTE_W-1:0] rsp_data,
    output logic [BYTE_W-1:0] opc_q,
    output logic [BYTE_W-1:0] adr_hi_q,
    output logic [BYTE_W-1:0] adr_mid_q,
    output logic [BYTE_W-1:0] adr_lo_q,
    output logic [BYTE_W-1:0] dat_q,
    output logic [BYTE_W-1:0] bus_rdata
);
    localparam logic [1:0] RSP_LAST = 2'(RESP_CNT - 1);

    logic [BYTE_W-1:0] rsp_q [RESP_CNT];

    // Store host command bytes while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opc_q     <= '0;
            adr_hi_q  <= '0;
            adr_mid_q <= '0;
            adr_lo_q  <= '0;
            dat_q     <= '0;
        end else if (bus_wr && !busy) begin
            case (bus_addr)
                OFS_OPC:   opc_q     <= bus_wdata;
                OFS_A_LO:  adr_lo_q  <= bus_wdata;
                OFS_A_MID: adr_mid_q <= bus_wdata;
                OFS_A_HI:  adr_hi_q  <= bus_wdata;
                OFS_DATA:  dat_q     <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Capture received bytes into the response slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < RESP_CNT; k++) rsp_q[k] <= '0;
        end else if (rsp_we && rsp_idx <= RSP_LAST) begin
            rsp_q[rsp_idx] <= rsp_data;
        end
    end

    // Read mux over the eight offsets.
    always_comb begin
        case (bus_addr)
            OFS_CTRL:  bus_rdata = {busy, 7'b0};
            OFS_OPC:   bus_rdata = opc_q;
            OFS_A_LO:  bus_rdata = adr_lo_q;
            OFS_A_MID: bus_rdata = adr_mid_q;
            OFS_A_HI:  bus_rdata = adr_hi_q;
            OFS_RSP0:  bus_rdata = rsp_q[0];
            OFS_RSP1:  bus_rdata = rsp_q[1];
            default:   bus_rdata = rsp_q[2];
        endcase
    end
endmodule

// File: rtl/spi_byte_shifter.sv
// Shifts one byte in SPI mode 0, MSB first, with clock half period CLK_DIV.
// Assumes start is pulsed only after done for the previous byte.
module spi_byte_shifter
    import spi_cmd_pkg::*;
#(
    parameter int CLK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              done,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] DIV_LAST = CW'(CLK_DIV - 1);
    localparam logic [2:0] BIT_LAST = 3'(BYTE_W - 1);

    logic [CW-1:0]     div_cnt;
    logic [2:0]        bit_cnt;
    logic              active;
    logic [BYTE_W-1:0] tx_sr;
    logic              tick;

    assign tick = active && (div_cnt == DIV_LAST);
    assign mosi = tx_sr[BYTE_W-1];

    // Clock divider, bit counter and the two shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            bit_cnt <= '0;
            active  <= 1'b0;
            tx_sr   <= '0;
            rx_byte <= '0;
            sck     <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                div_cnt <= '0;
                bit_cnt <= '0;
                active  <= 1'b1;
                tx_sr   <= tx_byte;
                sck     <= 1'b0;
            end else if (active) begin
                div_cnt <= tick ? '0 : div_cnt + 1'b1;
                if (tick) begin
                    if (!sck) begin
                        sck     <= 1'b1;
                        rx_byte <= {rx_byte[BYTE_W-2:0], miso};
                    end else begin
                        sck <= 1'b0;
                        if (bit_cnt == BIT_LAST) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                            tx_sr   <= {tx_sr[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi_cmd_seq.sv
// Command sequencer: orders bytes on the wire, drives chip-select and busy,
// and runs the page-program pass-through. Assumes one shifter.
module spi_cmd_seq
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              dat_wr,
    input  logic [BYTE_W-1:0] ctrl_val,
    input  logic [BYTE_W-1:0] opc,
    input  logic [BYTE_W-1:0] adr_hi,
    input  logic [BYTE_W-1:0] adr_mid,
    input  logic [BYTE_W-1:0] adr_lo,
    input  logic [BYTE_W-1:0] dat,
    input  logic              sh_done,
    output logic              sh_start,
    output logic [BYTE_W-1:0] sh_tx,
    output logic              cs_n,
    output logic              busy,
    output logic              page_mode,
    output logic              rsp_we,
    output logic [1:0]        rsp_idx
);
    seq_state_t state;
    logic [3:0] idx;
    logic [1:0] wcode;
    logic [1:0] rcount;
    logic [3:0] n_wr;
    logic [3:0] n_all;
    logic [3:0] rd_pos;

    assign n_wr   = wr_bytes(wcode);
    assign n_all  = n_wr + {2'b00, rcount};
    assign rd_pos = idx - n_wr;
    assign rsp_idx = rd_pos[1:0];
    assign rsp_we = sh_done && (state == SQ_SHIFT) && !page_mode && (idx >= n_wr);

    // Pick the byte for the current wire position.
    always_comb begin
        sh_tx = '0;
        if (idx == 4'd0) begin
            sh_tx = opc;
        end else if (wcode == WC_OPC_DAT) begin
            if (idx == 4'd1) sh_tx = dat;
        end else if (wcode[1]) begin
            case (idx)
                4'd1: sh_tx = adr_hi;
                4'd2: sh_tx = adr_mid;
                4'd3: sh_tx = adr_lo;
                4'd4: sh_tx = (wcode == WC_FULL) ? dat : '0;
                default: sh_tx = '0;
            endcase
        end
    end

    // Command state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            idx       <= '0;
            wcode     <= '0;
            rcount    <= '0;
            cs_n      <= 1'b1;
            busy      <= 1'b0;
            page_mode <= 1'b0;
            sh_start  <= 1'b0;
        end else begin
            sh_start <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (ctrl_wr && ctrl_val[7:4] == NIB_RUN) begin
                        wcode    <= ctrl_val[1:0];
                        rcount   <= ctrl_val[3:2];
                        idx      <= '0;
                        cs_n     <= 1'b0;
                        busy     <= 1'b1;
                        sh_start <= 1'b1;
                        state    <= SQ_SHIFT;
                    end else if (ctrl_wr && ctrl_val[7:4] == NIB_PAGE) begin
                        wcode     <= WC_OPC_DAT;
                        rcount    <= '0;
                        idx       <= '0;
                        cs_n      <= 1'b0;
                        busy      <= 1'b1;
                        page_mode <= 1'b1;
                        sh_start  <= 1'b1;
                        state     <= SQ_SHIFT;
                    end
                end
                SQ_SHIFT: begin
                    if (sh_done) begin
                        if (page_mode) begin
                            busy  <= 1'b0;
                            state <= SQ_PAGE;
                        end else if (idx + 4'd1 == n_all) begin
                            cs_n  <= 1'b1;
                            state <= SQ_CLOSE;
                        end else begin
                            idx      <= idx + 4'd1;
                            sh_start <= 1'b1;
                        end
                    end
                end
                SQ_CLOSE: begin
                    busy  <= 1'b0;
                    state <= SQ_IDLE;
                end
                SQ_PAGE: begin
                    if (ctrl_wr && ctrl_val == '0) begin
                        cs_n      <= 1'b1;
                        page_mode <= 1'b0;
                        state     <= SQ_IDLE;
                    end else if (dat_wr) begin
                        idx      <= 4'd1;
                        busy     <= 1'b1;
                        sh_start <= 1'b1;
                        state    <= SQ_SHIFT;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_cmd_engine.sv
// Top level: register-mapped SPI command engine with page-program pass-through.
// Assumes the host polls busy at offset 0 before issuing the next command.
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int CLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       spi_sck,
    output logic       spi_cs_n,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    logic              busy;
    logic              page_mode;
    logic              rsp_we;
    logic [1:0]        rsp_idx;
    logic [BYTE_W-1:0] opc_q, adr_hi_q, adr_mid_q, adr_lo_q, dat_q;
    logic              sh_start, sh_done;
    logic [BYTE_W-1:0] sh_tx, sh_rx;
    logic              ctrl_wr, dat_wr;

    assign ctrl_wr = bus_wr && (bus_addr == OFS_CTRL);
    assign dat_wr  = bus_wr && (bus_addr == OFS_DATA);

    spi_cmd_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .rsp_we    (rsp_we),
        .rsp_idx   (rsp_idx),
        .rsp_data  (sh_rx),
        .opc_q     (opc_q),
        .adr_hi_q  (adr_hi_q),
        .adr_mid_q (adr_mid_q),
        .adr_lo_q  (adr_lo_q),
        .dat_q     (dat_q),
        .bus_rdata (bus_rdata)
    );

    spi_cmd_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .dat_wr    (dat_wr),
        .ctrl_val  (bus_wdata),
        .opc       (opc_q),
        .adr_hi    (adr_hi_q),
        .adr_mid   (adr_mid_q),
        .adr_lo    (adr_lo_q),
        .dat       (dat_q),
        .sh_done   (sh_done),
        .sh_start  (sh_start),
        .sh_tx     (sh_tx),
        .cs_n      (spi_cs_n),
        .busy      (busy),
        .page_mode (page_mode),
        .rsp_we    (rsp_we),
        .rsp_idx   (rsp_idx)
    );

    spi_byte_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .tx_byte (sh_tx),
        .miso    (spi_miso),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .done    (sh_done),
        .rx_byte (sh_rx)
    );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
// Protocol checker for spi_cmd_engine, attached with bind below.
// Assumes it observes the top-level ports plus busy, page_mode and opc_q.
module spi_cmd_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] bus_addr,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic       spi_sck,
    input logic       spi_cs_n,
    input logic       spi_mosi,
    input logic       busy,
    input logic       page_mode,
    input logic [7:0] opc_q
);
    AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck); // R6
    AST_MOSI_HELD_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi)); // R6
    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0 && bus_wdata[7:4] == 4'h5 && !busy && !page_mode) |=> busy); // R3
    AST_BUSY_DROP_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !page_mode) |-> spi_cs_n); // R7
    AST_OPCODE_LOCKED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr && bus_addr == 3'd1) |=> $stable(opc_q)); // R8
    AST_PAGE_KEEPS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        page_mode |-> !spi_cs_n); // R10
endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .spi_sck   (spi_sck),
    .spi_cs_n  (spi_cs_n),
    .spi_mosi  (spi_mosi),
    .busy      (busy),
    .page_mode (page_mode),
    .opc_q     (opc_q)
);

// File: tb/spi_cmd_engine_bench.sv
module spi_cmd_engine_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       spi_sck, spi_cs_n, spi_mosi;
    logic       spi_miso;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cmd_engine u_spi_cmd_engine (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // Flash model: records MOSI bytes, answers 0xA0 + byte position.
    logic [7:0] wire_q [16];
    int         wire_n = 0;
    int         cs_falls = 0;
    int         nb = 0;
    logic [7:0] rxs = '0;
    logic [7:0] osr = 8'hA0;
    logic       prev_cs = 1'b1;
    logic       prev_sck = 1'b0;
    assign spi_miso = osr[7];

    always @(spi_cs_n or spi_sck) begin
        if (prev_cs === 1'b1 && spi_cs_n === 1'b0) begin
            nb = 0; wire_n = 0; osr = 8'hA0; cs_falls++;
        end
        if (prev_sck === 1'b0 && spi_sck === 1'b1 && spi_cs_n === 1'b0) begin
            rxs = {rxs[6:0], spi_mosi}; nb++;
        end
        if (prev_sck === 1'b1 && spi_sck === 1'b0 && spi_cs_n === 1'b0) begin
            if (nb == 8) begin
                if (wire_n < 16) wire_q[wire_n] = rxs;
                wire_n++; nb = 0; osr = 8'(8'hA0 + wire_n);
            end else begin
                osr = {osr[6:0], 1'b0};
            end
        end
        prev_cs = spi_cs_n;
        prev_sck = spi_sck;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle(input string req);
        logic [7:0] s;
        int guard = 0;
        bus_read(3'd0, s);
        while (s[7] && guard < 5000) begin
            @(negedge clk); guard++;
            bus_read(3'd0, s);
        end
        chk(req, "busy clears", {31'b0, s[7]}, 32'd0);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R1", "cs_n after reset", {31'b0, spi_cs_n}, 32'd1);
        chk("R1", "sck after reset", {31'b0, spi_sck}, 32'd0);
        bus_read(3'd0, d); chk("R1", "status after reset", {24'b0, d}, 32'h00);
        for (int k = 1; k <= 4; k++) begin
            bus_read(3'(k), d); chk("R1", "reg after reset", {24'b0, d}, 32'h00);
        end
    endtask

    task automatic t_regs;
        logic [7:0] d;
        bus_write(3'd1, 8'h3C); bus_write(3'd2, 8'h11);
        bus_write(3'd3, 8'h22); bus_write(3'd4, 8'h33);
        @(negedge clk);
        bus_read(3'd1, d); chk("R2", "opcode readback", {24'b0, d}, 32'h3C);
        bus_read(3'd2, d); chk("R2", "offset 2 readback", {24'b0, d}, 32'h11);
        bus_read(3'd3, d); chk("R2", "offset 3 readback", {24'b0, d}, 32'h22);
        bus_read(3'd4, d); chk("R2", "offset 4 readback", {24'b0, d}, 32'h33);
        bus_read(3'd0, d); chk("R2", "status idle", {24'b0, d}, 32'h00);
    endtask

    task automatic t_command(input string tag, input logic [7:0] op, input logic [1:0] wc,
                             input logic [1:0] rc, input logic [7:0] hi, input logic [7:0] mid,
                             input logic [7:0] lo, input logic [7:0] dat);
        logic [7:0] exp_b [8];
        logic [7:0] d;
        logic [7:0] old7;
        int ne;
        bus_read(3'd7, old7);
        exp_b[0] = op; ne = 1;
        if (wc == 2'd1) begin exp_b[1] = dat; ne = 2; end
        if (wc[1]) begin exp_b[1] = hi; exp_b[2] = mid; exp_b[3] = lo; ne = 4; end
        if (wc == 2'd3) begin exp_b[4] = dat; ne = 5; end
        for (int j = 0; j < 3; j++) if (j < int'(rc)) exp_b[ne + j] = 8'h00;
        bus_write(3'd1, op); bus_write(3'd4, hi); bus_write(3'd3, mid);
        bus_write(3'd2, lo); bus_write(3'd7, dat);
        bus_write(3'd0, {4'h5, rc, wc});
        bus_read(3'd0, d);
        chk("R3", {tag, " busy after start"}, {31'b0, d[7]}, 32'd1);
        wait_idle("R7");
        chk("R7", {tag, " cs_n high at idle"}, {31'b0, spi_cs_n}, 32'd1);
        chk("R6", {tag, " sck idle low"}, {31'b0, spi_sck}, 32'd0);
        chk("R4", {tag, " byte count"}, wire_n, ne + int'(rc));
        for (int j = 0; j < ne + int'(rc); j++)
            chk(j < ne ? "R4" : "R5", {tag, " wire byte"}, {24'b0, wire_q[j]}, {24'b0, exp_b[j]});
        for (int j = 0; j < 3; j++) begin
            bus_read(3'(5 + j), d);
            if (j < int'(rc))
                chk("R5", {tag, " response"}, {24'b0, d}, 32'(8'hA0 + ne + j));
            else if (j == 2)
                chk("R5", {tag, " unread slot kept"}, {24'b0, d}, {24'b0, old7});
        end
    endtask

    task automatic t_busy_ignore;
        logic [7:0] d;
        int f0;
        bus_write(3'd1, 8'h06);
        f0 = cs_falls;
        bus_write(3'd0, 8'h50);
        bus_write(3'd1, 8'h55);
        bus_write(3'd0, 8'h5F);
        wait_idle("R8");
        bus_read(3'd1, d); chk("R8", "opcode write during busy", {24'b0, d}, 32'h06);
        chk("R8", "start during busy", cs_falls - f0, 32'd1);
        chk("R8", "bytes of single command", wire_n, 32'd1);
    endtask

    task automatic t_bad_nibble;
        logic [7:0] d;
        int f0 = cs_falls;
        bus_write(3'd0, 8'h92);
        bus_write(3'd0, 8'h11);
        repeat (4) @(negedge clk);
        bus_read(3'd0, d);
        chk("R9", "busy after bad nibble", {24'b0, d}, 32'h00);
        chk("R9", "no select on bad nibble", cs_falls - f0, 32'd0);
        chk("R9", "cs_n stays high", {31'b0, spi_cs_n}, 32'd1);
    endtask

    task automatic t_page;
        logic [7:0] d;
        bus_write(3'd1, 8'h02);
        bus_write(3'd0, 8'h30);
        bus_read(3'd0, d); chk("R10", "busy on opcode", {31'b0, d[7]}, 32'd1);
        wait_idle("R10");
        chk("R10", "cs_n held low", {31'b0, spi_cs_n}, 32'd0);
        chk("R10", "opcode sent", {24'b0, wire_q[0]}, 32'h02);
        bus_write(3'd7, 8'hC3);
        bus_read(3'd0, d); chk("R10", "busy on data", {31'b0, d[7]}, 32'd1);
        wait_idle("R10");
        bus_write(3'd7, 8'h5A);
        wait_idle("R10");
        chk("R10", "page byte count", wire_n, 32'd3);
        chk("R10", "first data byte", {24'b0, wire_q[1]}, 32'hC3);
        chk("R10", "second data byte", {24'b0, wire_q[2]}, 32'h5A);
        chk("R10", "cs_n low between bytes", {31'b0, spi_cs_n}, 32'd0);
        bus_write(3'd0, 8'h00);
        chk("R11", "cs_n released", {31'b0, spi_cs_n}, 32'd1);
        bus_read(3'd0, d); chk("R11", "idle after exit", {24'b0, d}, 32'h00);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_command("id", 8'h9F, 2'd0, 2'd3, 8'h00, 8'h00, 8'h00, 8'h00);
        t_command("dat", 8'h01, 2'd1, 2'd1, 8'h00, 8'h00, 8'h00, 8'h7E);
        t_command("adr", 8'hD8, 2'd2, 2'd0, 8'h12, 8'h34, 8'h56, 8'h00);
        t_command("full", 8'h20, 2'd3, 2'd2, 8'h81, 8'h42, 8'h18, 8'hE7);
        t_busy_ignore();
        t_bad_nibble();
        t_page();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule